// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block sits behind a two-channel sampler and turns the raw sample words into the words that leave the chip. Each channel delivers a 10-bit offset-binary word plus an over-range and an under-range flag. A 2-bit mode code picks the output coding, which is either the raw offset-binary word or two's complement. The same code also carries a clock-stabilizer enable. The block does not use that bit itself; it only reports it on an output.

A swap control decides which channel feeds which of the two output buses. Each bus has an active-low output enable and a power-down status. When a bus is gated, it drives zero and drops its enable indication, which stands in for high impedance. The flags of both channels merge into one overflow output. That output is gated by side A's power-down status and output enable. The output clock is a one-cycle delayed copy of channel B's sample clock and is gated by side B's power-down status. Downstream logic captures data on the falling edge of this clock. Every output is registered once on `clk_i`.

Top module: `conv_out_fmt`

## Requirements
- R1: Mode codes 0 and 1 select offset binary: a bus carries its channel's sample word unchanged.
- R2: Mode codes 2 and 3 select two's complement: a bus carries its channel's sample word with bit 9 (the MSB) inverted and the other bits unchanged.
- R3: `stab_o` is 1 for mode codes 1 and 2 and 0 for codes 0 and 3.
- R4: With `swap_i` = 1, channel A feeds `bus_a_o` and channel B feeds `bus_b_o`. With `swap_i` = 0, channel A feeds `bus_b_o` and channel B feeds `bus_a_o`.
- R5: `ovf_o` is the OR of the over-range and under-range flags of both channels, whatever the value of `swap_i`.
- R6: When `pd_a_i` = 1 or `oe_a_ni` = 1, `ovf_o` and `ovf_en_o` are 0, whatever the flags.
- R7: Bus A is enabled only when `oe_a_ni` = 0 and `pd_a_i` = 0, and bus B only when `oe_b_ni` = 0 and `pd_b_i` = 0. A disabled bus drives all zeros with its enable output at 0.
- R8: `clk_out_o` equals `sclk_b_i` delayed by one `clk_i` cycle. When `pd_b_i` = 1, `clk_out_o` and `clk_out_en_o` are 0.
- R9: Every output reflects the inputs of the previous rising edge of `clk_i`, which is one cycle of latency. While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Coding and stabilizer mode code |
| swap_i | input | 1 | Channel-to-bus routing select |
| a_data_i | input | 10 | Channel A offset-binary sample |
| a_ovr_i | input | 1 | Channel A over-range flag |
| a_und_i | input | 1 | Channel A under-range flag |
| b_data_i | input | 10 | Channel B offset-binary sample |
| b_ovr_i | input | 1 | Channel B over-range flag |
| b_und_i | input | 1 | Channel B under-range flag |
| oe_a_ni | input | 1 | Bus A output enable, active low |
| oe_b_ni | input | 1 | Bus B output enable, active low |
| pd_a_i | input | 1 | Side A in sleep or nap |
| pd_b_i | input | 1 | Side B in sleep or nap |
| sclk_b_i | input | 1 | Channel B sample clock level |
| bus_a_o | output | 10 | Output bus A |
| bus_a_en_o | output | 1 | Bus A driven |
| bus_b_o | output | 10 | Output bus B |
| bus_b_en_o | output | 1 | Bus B driven |
| ovf_o | output | 1 | Shared overflow flag |
| ovf_en_o | output | 1 | Overflow output driven |
| clk_out_o | output | 1 | Delayed sample clock |
| clk_out_en_o | output | 1 | Output clock driven |
| stab_o | output | 1 | Reported stabilizer enable |

## Verification
The bench checks the four mode codes one by one. It looks for a design that inverts the wrong bit or mixes up the stabilizer codes 1 and 2 in the decode. It checks the swap in both directions with different data on each channel, so a design that routes the buses backwards shows up as crossed data. It sets a flag on one channel while side A is powered down, side B is disabled, or both. This exposes overflow gating taken from the wrong side, a flag lost when the buses are swapped, and a gated bus that still carries data. It toggles the sample clock of channel B while side B is powered down, which exposes a clock output that leaks through, or one that appears a cycle early or late.

// File: rtl/conv_out_fmt_pkg.sv
package conv_out_fmt_pkg;
  typedef enum logic {FMT_OFFSET = 1'b0, FMT_TWOS = 1'b1} fmt_e;

  typedef struct packed {
    fmt_e fmt;
    logic stab;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [1:0] code);
    mode_cfg_t c;
    c.fmt  = code[1] ? FMT_TWOS : FMT_OFFSET;
    c.stab = code[1] ^ code[0];
    return c;
  endfunction
endpackage

// File: rtl/cof_chan.sv
module cof_chan #(
  parameter int W = 10
) (
  input  logic [W-1:0] data_i,
  input  logic         ovr_i,
  input  logic         und_i,
  input  conv_out_fmt_pkg::fmt_e fmt_i,
  output logic [W-1:0] word_o,
  output logic         flag_o
);
  import conv_out_fmt_pkg::*;
  localparam int MSB = W - 1;

  always_comb begin
    word_o = data_i;
    if (fmt_i == FMT_TWOS) word_o[MSB] = ~data_i[MSB];
    flag_o = ovr_i | und_i;
  end
endmodule

// File: rtl/cof_route.sv
module cof_route #(
  parameter int W = 10,
  parameter int NCH = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NCH-1:0][W-1:0]    word_i,
  input  logic [NCH-1:0]           flag_i,
  input  logic                     swap_i,
  input  logic [NCH-1:0]           oe_ni,
  input  logic [NCH-1:0]           pd_i,
  output logic [NCH-1:0][W-1:0]    bus_o,
  output logic [NCH-1:0]           bus_en_o,
  output logic                     ovf_o,
  output logic                     ovf_en_o
);
  logic [NCH-1:0] live;
  logic           chk_q;

  // swap high: straight routing; swap low: crossed
  for (genvar g = 0; g < NCH; g++) begin : g_bus
    localparam int XSRC = NCH - 1 - g;
    logic [W-1:0] sel;
    assign live[g] = ~oe_ni[g] & ~pd_i[g];
    assign sel     = swap_i ? word_i[g] : word_i[XSRC];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bus_o[g]    <= '0;
        bus_en_o[g] <= 1'b0;
      end else begin
        bus_o[g]    <= live[g] ? sel : '0;
        bus_en_o[g] <= live[g];
      end
    end

    AST_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_en_o[g] |-> (bus_o[g] == '0)); // R7
    AST_BUS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_q)
      bus_en_o[g] == $past(!oe_ni[g] && !pd_i[g])); // R7
  end

  // overflow side follows channel A power and enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o    <= 1'b0;
      ovf_en_o <= 1'b0;
      chk_q    <= 1'b0;
    end else begin
      ovf_o    <= live[0] & (|flag_i);
      ovf_en_o <= live[0];
      chk_q    <= 1'b1;
    end
  end

  AST_OVF_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_q)
    $past(pd_i[0] || oe_ni[0]) |-> (!ovf_o && !ovf_en_o)); // R6
  AST_OVF_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_q)
    $past(!pd_i[0] && !oe_ni[0]) |-> (ovf_o == $past(|flag_i))); // R5
endmodule

// File: rtl/cof_clkout.sv
module cof_clkout (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic pd_i,
  output logic clk_out_o,
  output logic clk_out_en_o
);
  logic chk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_out_o    <= 1'b0;
      clk_out_en_o <= 1'b0;
      chk_q        <= 1'b0;
    end else begin
      clk_out_o    <= sclk_i & ~pd_i;
      clk_out_en_o <= ~pd_i;
      chk_q        <= 1'b1;
    end
  end

  AST_CLK_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_q)
    $past(!pd_i) |-> (clk_out_o == $past(sclk_i))); // R8
  AST_CLK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_q)
    $past(pd_i) |-> (!clk_out_o && !clk_out_en_o)); // R8
endmodule

// File: rtl/conv_out_fmt.sv
module conv_out_fmt #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   mode_i,
  input  logic         swap_i,
  input  logic [W-1:0] a_data_i,
  input  logic         a_ovr_i,
  input  logic         a_und_i,
  input  logic [W-1:0] b_data_i,
  input  logic         b_ovr_i,
  input  logic         b_und_i,
  input  logic         oe_a_ni,
  input  logic         oe_b_ni,
  input  logic         pd_a_i,
  input  logic         pd_b_i,
  input  logic         sclk_b_i,
  output logic [W-1:0] bus_a_o,
  output logic         bus_a_en_o,
  output logic [W-1:0] bus_b_o,
  output logic         bus_b_en_o,
  output logic         ovf_o,
  output logic         ovf_en_o,
  output logic         clk_out_o,
  output logic         clk_out_en_o,
  output logic         stab_o
);
  import conv_out_fmt_pkg::*;
  localparam int NCH = 2;
  localparam int MSB = W - 1;

  mode_cfg_t                cfg;
  logic [NCH-1:0][W-1:0]    raw, word, bus;
  logic [NCH-1:0]           ovr, und, flag, bus_en;
  logic                     chk_q;

  assign cfg    = decode_mode(mode_i);
  assign raw[0] = a_data_i;
  assign raw[1] = b_data_i;
  assign ovr    = {b_ovr_i, a_ovr_i};
  assign und    = {b_und_i, a_und_i};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    cof_chan #(.W(W)) u_chan (
      .data_i (raw[c]),
      .ovr_i  (ovr[c]),
      .und_i  (und[c]),
      .fmt_i  (cfg.fmt),
      .word_o (word[c]),
      .flag_o (flag[c])
    );
  end

  cof_route #(.W(W), .NCH(NCH)) u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .word_i   (word),
    .flag_i   (flag),
    .swap_i   (swap_i),
    .oe_ni    ({oe_b_ni, oe_a_ni}),
    .pd_i     ({pd_b_i, pd_a_i}),
    .bus_o    (bus),
    .bus_en_o (bus_en),
    .ovf_o    (ovf_o),
    .ovf_en_o (ovf_en_o)
  );

  cof_clkout u_clkout (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_i       (sclk_b_i),
    .pd_i         (pd_b_i),
    .clk_out_o    (clk_out_o),
    .clk_out_en_o (clk_out_en_o)
  );

  assign bus_a_o    = bus[0];
  assign bus_b_o    = bus[1];
  assign bus_a_en_o = bus_en[0];
  assign bus_b_en_o = bus_en[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stab_o <= 1'b0;
      chk_q  <= 1'b0;
    end else begin
      stab_o <= cfg.stab;
      chk_q  <= 1'b1;
    end
  end

  AST_STAB_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_q)
    stab_o == $past(mode_i == 2'd1 || mode_i == 2'd2)); // R3
  AST_SWAP_STRAIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_q)
    (bus_a_en_o && $past(swap_i)) |->
      (bus_a_o[MSB-1:0] == $past(a_data_i[MSB-1:0]))); // R4
  AST_TWOS_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_q)
    (bus_a_en_o && $past(swap_i && mode_i[1])) |->
      (bus_a_o[MSB] == !$past(a_data_i[MSB]))); // R2
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!bus_a_en_o && !bus_b_en_o && !ovf_o && !clk_out_o && !stab_o)); // R9
endmodule

// File: tb/conv_out_fmt_tb.sv
module conv_out_fmt_tb;
  localparam int W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode;
  logic swap, a_ovr, a_und, b_ovr, b_und, oe_a_n, oe_b_n, pd_a, pd_b, sclk;
  logic [W-1:0] a_data, b_data;
  logic [W-1:0] bus_a, bus_b;
  logic bus_a_en, bus_b_en, ovf, ovf_en, clk_out, clk_out_en, stab;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  conv_out_fmt #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .swap_i(swap),
    .a_data_i(a_data), .a_ovr_i(a_ovr), .a_und_i(a_und),
    .b_data_i(b_data), .b_ovr_i(b_ovr), .b_und_i(b_und),
    .oe_a_ni(oe_a_n), .oe_b_ni(oe_b_n), .pd_a_i(pd_a), .pd_b_i(pd_b),
    .sclk_b_i(sclk),
    .bus_a_o(bus_a), .bus_a_en_o(bus_a_en), .bus_b_o(bus_b), .bus_b_en_o(bus_b_en),
    .ovf_o(ovf), .ovf_en_o(ovf_en), .clk_out_o(clk_out), .clk_out_en_o(clk_out_en),
    .stab_o(stab)
  );

  function automatic logic [W-1:0] fmt_word(logic [W-1:0] d, logic [1:0] m);
    return m[1] ? {~d[W-1], d[W-2:0]} : d;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(logic [1:0] m, logic sw, logic [W-1:0] da, logic [W-1:0] db,
                       logic [3:0] flags, logic [1:0] oen, logic [1:0] pd, logic sc);
    mode = m; swap = sw; a_data = da; b_data = db;
    {b_und, b_ovr, a_und, a_ovr} = flags;
    {oe_b_n, oe_a_n} = oen; {pd_b, pd_a} = pd; sclk = sc;
  endtask

  // inputs held since last negedge; outputs settle after the posedge between
  task automatic step_and_check();
    logic [W-1:0] src_a, src_b, ea, eb;
    logic ena, enb;
    @(negedge clk);
    src_a = swap ? a_data : b_data;
    src_b = swap ? b_data : a_data;
    ena = !oe_a_n && !pd_a;
    enb = !oe_b_n && !pd_b;
    ea = ena ? fmt_word(src_a, mode) : '0;
    eb = enb ? fmt_word(src_b, mode) : '0;
    check(mode[1] ? "R2/R4 bus_a" : "R1/R4 bus_a", 32'(bus_a), 32'(ea));
    check(mode[1] ? "R2/R4 bus_b" : "R1/R4 bus_b", 32'(bus_b), 32'(eb));
    check("R7 bus_a_en", 32'(bus_a_en), 32'(ena));
    check("R7 bus_b_en", 32'(bus_b_en), 32'(enb));
    check("R5/R6 ovf", 32'(ovf), 32'(ena && (a_ovr || a_und || b_ovr || b_und)));
    check("R6 ovf_en", 32'(ovf_en), 32'(ena));
    check("R8 clk_out", 32'(clk_out), 32'(sclk && !pd_b));
    check("R8 clk_out_en", 32'(clk_out_en), 32'(!pd_b));
    check("R3 stab", 32'(stab), 32'(mode == 2'd1 || mode == 2'd2));
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    drive(2'd2, 1'b1, 10'h3ff, 10'h155, 4'hf, 2'b00, 2'b00, 1'b1);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset bus_a", 32'(bus_a), 0);
    check("R9 reset bus_a_en", 32'(bus_a_en), 0);
    check("R9 reset ovf", 32'(ovf), 0);
    check("R9 reset clk_out", 32'(clk_out), 0);
    check("R9 reset stab", 32'(stab), 0);
    rst_n = 1'b1;
    // R1 R2 R3: each mode, both swaps
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        drive(2'(m), 1'(s), 10'h2a5, 10'h0f3, 4'h0, 2'b00, 2'b00, 1'(m & 1));
        step_and_check();
      end
    end
    // R5 single flags with crossed swap; R6 gating by side A
    for (int f = 0; f < 4; f++) begin
      drive(2'd0, 1'b0, 10'h200, 10'h1ff, 4'(1 << f), 2'b00, 2'b00, 1'b0);
      step_and_check();
      drive(2'd0, 1'b1, 10'h200, 10'h1ff, 4'(1 << f), 2'b00, 2'b01, 1'b0);
      step_and_check();
      drive(2'd0, 1'b1, 10'h200, 10'h1ff, 4'(1 << f), 2'b01, 2'b00, 1'b0);
      step_and_check();
      drive(2'd0, 1'b1, 10'h200, 10'h1ff, 4'(1 << f), 2'b10, 2'b10, 1'b1);
      step_and_check();
    end
    // R8 sample clock toggling while side B powered down and up
    for (int k = 0; k < 8; k++) begin
      drive(2'd3, 1'b0, 10'h000, 10'h3ff, 4'h0, 2'b00, 2'((k >> 2) << 1), 1'(k & 1));
      step_and_check();
    end
    // random mix; R9 latency checked by every step
    for (int i = 0; i < 3000; i++) begin
      drive(2'($urandom), 1'($urandom), 10'($urandom), 10'($urandom), 4'($urandom),
            2'($urandom), ($urandom % 4 == 0) ? 2'($urandom) : 2'b00, 1'($urandom));
      step_and_check();
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule